// File: doc/BRIEF.md
# Crosspoint Sweep Pattern Sequencer

This block drives the test-side controls of a self-testing two-level array: the true values of the input lines, two switches that force every true or every complemented row to zero, and a mask with one bit per product line that can switch any product line off. A single `start` pulse runs a fixed pattern sequence. The sequence does not depend on the logic programmed into the array. While it runs, a separate parity comparator reads the array outputs. The block gives that comparator a hold strobe and two start strobes.

The sequence has five stages. First comes one pattern with every product line off. Next are two sweeps that turn on one product line at a time while both row groups are forced low. Last are two crosspoint sweeps, one over the true rows and one over the complemented rows. Each crosspoint sweep walks a single enabled product line past one selected input row, then moves to the next row. The product-line walker steps every clock. The input-row walker keeps its selection for a whole product sweep and steps only once every `N_PROD` clocks. After the last pattern the block goes back to normal mode and reports done until the next `start`.

All pins are plain level or pulse controls. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sweep_seq_top`

## Requirements
- R1: After reset, `phase` is 0 (idle), `true_off`, `comp_off`, `done`, `cmp_start_a` and `cmp_start_b` are 0, `cmp_hold` is 1, `pla_x` is all zero and `prod_off` is all ones.
- R2: When `start` is high at a clock edge while `phase` is 0 or 6, the next cycle has `phase`=1. That single cycle has `prod_off` all ones, both force switches at 0, `pla_x` zero and `cmp_start_a`=1.
- R3: Phase 2 and then phase 3 each last `N_PROD` cycles with `true_off`=`comp_off`=1. In cycle j (0-based) of each, only `prod_off[j]` is 0. `pla_x` is all zero in phase 2 and all ones in phase 3. `cmp_start_b` is 1 only in the first cycle of phase 3.
- R4: Phase 4 lasts `N_IN*N_PROD` cycles with `true_off`=0 and `comp_off`=1. In cycle t, `pla_x` has only bit t/`N_PROD` set and only `prod_off[t mod N_PROD]` is 0, so the product index runs fastest.
- R5: Phase 5 repeats the phase 4 ordering with `true_off`=1, `comp_off`=0 and `pla_x` equal to the complement of that one-hot row vector.
- R6: `cmp_hold` is 0 only in the last product cycle of each row in phases 4 and 5. In every other cycle of those phases, `pla_x` keeps its value into the next cycle.
- R7: From phase 1 through the end of phase 5 the sequence lasts 2·`N_IN`·`N_PROD` + 2·`N_PROD` + 1 cycles. It then enters phase 6 with `done`=1, both switches at 0, `prod_off` all ones and `pla_x` zero, and stays there until `start`.
- R8: At no time is more than one bit of `prod_off` at 0.
- R9: `start` has no effect while `phase` is between 1 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a sequence when idle or done |
| pla_x | output | N_IN | True values applied to the input rows |
| true_off | output | 1 | Forces all true rows to 0 |
| comp_off | output | 1 | Forces all complemented rows to 0 |
| prod_off | output | N_PROD | Per product line disable, 0 enables the line |
| phase | output | 3 | 0 idle, 1 all-off, 2 and 3 product sweeps, 4 true sweep, 5 complement sweep, 6 done |
| cmp_hold | output | 1 | Low in the cycle where the row walker advances |
| cmp_start_a | output | 1 | Pulse in the first pattern |
| cmp_start_b | output | 1 | Pulse in the first cycle of phase 3 |
| done | output | 1 | Sequence finished, normal mode |

## Verification
The assertions assume `start` is synchronous to `clk` and that reset is applied before the first sequence. Beyond that they make no assumption about `start`: it may be high in any cycle. They also rely on the walkers being loaded only through the sequencer, so that a product sweep always begins with exactly one active line. The stimulus meets these assumptions by changing `start` only on the falling edge. It also raises `start` at random cycles during a running sequence, so the check that `start` is ignored while running gets exercised.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ALL  = 3'd1,
    PH_ORA  = 3'd2,
    PH_ORB  = 3'd3,
    PH_TRUE = 3'd4,
    PH_COMP = 3'd5,
    PH_DONE = 3'd6
  } phase_t;
endpackage

// File: rtl/prod_walker.sv
module prod_walker #(
  parameter int N_PROD = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              seed,
  input  logic              adv,
  output logic [N_PROD-1:0] act,
  output logic              at_last
);
  for (genvar b = 0; b < N_PROD; b++) begin : g_cell
    localparam int SRC = (b == 0) ? N_PROD - 1 : b - 1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act[b] <= 1'b0;
      else if (clr)  act[b] <= 1'b0;
      else if (seed) act[b] <= (b == 0);
      else if (adv)  act[b] <= act[SRC];
    end
  end

  assign at_last = act[N_PROD-1];

  a_r8_single_line: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(act));
  a_r3_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !seed && act[0]) |=> act[(N_PROD > 1) ? 1 : 0]);
endmodule

// File: rtl/line_walker.sv
module line_walker #(
  parameter int N_IN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic            adv,
  output logic [N_IN-1:0] sel,
  output logic            at_last
);
  for (genvar b = 0; b < N_IN; b++) begin : g_cell
    localparam int SRC = (b == 0) ? N_IN - 1 : b - 1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel[b] <= 1'b0;
      else if (init) sel[b] <= (b == 0);
      else if (adv)  sel[b] <= sel[SRC];
    end
  end

  assign at_last = sel[N_IN-1];

  a_r6_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !adv) |=> $stable(sel));
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import sweep_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   prod_last,
  input  logic   line_last,
  output phase_t phase,
  output logic   prod_clr,
  output logic   prod_seed,
  output logic   prod_adv,
  output logic   line_init,
  output logic   line_adv
);
  phase_t nxt;

  always_comb begin
    nxt       = phase;
    prod_clr  = 1'b0;
    prod_seed = 1'b0;
    prod_adv  = 1'b0;
    line_init = 1'b0;
    line_adv  = 1'b0;
    unique case (phase)
      PH_IDLE, PH_DONE: if (start) begin
        nxt       = PH_ALL;
        prod_clr  = 1'b1;
        line_init = 1'b1;
      end
      PH_ALL: begin
        nxt       = PH_ORA;
        prod_seed = 1'b1;
      end
      PH_ORA: begin
        prod_adv = 1'b1;
        if (prod_last) nxt = PH_ORB;
      end
      PH_ORB: begin
        prod_adv = 1'b1;
        if (prod_last) nxt = PH_TRUE;
      end
      PH_TRUE: begin
        prod_adv = 1'b1;
        if (prod_last) begin
          if (line_last) begin
            nxt       = PH_COMP;
            line_init = 1'b1;
          end else begin
            line_adv = 1'b1;
          end
        end
      end
      PH_COMP: begin
        if (prod_last && line_last) begin
          nxt      = PH_DONE;
          prod_clr = 1'b1;
        end else begin
          prod_adv = 1'b1;
          line_adv = prod_last;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (phase inside {PH_ORA, PH_ORB, PH_TRUE, PH_COMP}) |=> (phase != PH_ALL));
  a_r2_all_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ALL) |=> (phase == PH_ORA));
endmodule

// File: rtl/sweep_seq_top.sv
module sweep_seq_top
  import sweep_seq_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_PROD = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [N_IN-1:0]   pla_x,
  output logic              true_off,
  output logic              comp_off,
  output logic [N_PROD-1:0] prod_off,
  output logic [2:0]        phase,
  output logic              cmp_hold,
  output logic              cmp_start_a,
  output logic              cmp_start_b,
  output logic              done
);
  phase_t            ph;
  logic              prod_clr, prod_seed, prod_adv, line_init, line_adv;
  logic              prod_last, line_last;
  logic [N_PROD-1:0] act;
  logic [N_IN-1:0]   line;

  phase_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .prod_last(prod_last), .line_last(line_last), .phase(ph),
    .prod_clr(prod_clr), .prod_seed(prod_seed), .prod_adv(prod_adv),
    .line_init(line_init), .line_adv(line_adv)
  );

  prod_walker #(.N_PROD(N_PROD)) u_prod (
    .clk(clk), .rst_n(rst_n), .clr(prod_clr), .seed(prod_seed),
    .adv(prod_adv), .act(act), .at_last(prod_last)
  );

  line_walker #(.N_IN(N_IN)) u_line (
    .clk(clk), .rst_n(rst_n), .init(line_init), .adv(line_adv),
    .sel(line), .at_last(line_last)
  );

  logic in_cross;
  assign in_cross = (ph == PH_TRUE) || (ph == PH_COMP);

  always_comb begin
    unique case (ph)
      PH_ORB:  pla_x = '1;
      PH_TRUE: pla_x = line;
      PH_COMP: pla_x = ~line;
      default: pla_x = '0;
    endcase
  end

  assign true_off    = (ph == PH_ORA) || (ph == PH_ORB) || (ph == PH_COMP);
  assign comp_off    = (ph == PH_ORA) || (ph == PH_ORB) || (ph == PH_TRUE);
  assign prod_off    = ~act;
  assign phase       = ph;
  assign cmp_hold    = !(in_cross && prod_last);
  assign cmp_start_a = (ph == PH_ALL);
  assign cmp_start_b = (ph == PH_ORB) && act[0];
  assign done        = (ph == PH_DONE);

  a_r7_done_normal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&prod_off && !true_off && !comp_off));
  a_r4_true_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_TRUE) |-> ($onehot(pla_x) && $countones(prod_off) == N_PROD - 1));
  a_r6_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cross && cmp_hold) |=> $stable(pla_x));
  a_r2_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_start_a |-> &prod_off);
endmodule

// File: tb/sim_sweep_seq_top.sv
module sim_sweep_seq_top;
  localparam int NI = 4;
  localparam int NP = 6;
  localparam int LEN = 2 * NI * NP + 2 * NP + 1;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [NI-1:0] pla_x;
  logic [NP-1:0] prod_off;
  logic [2:0] phase;
  logic true_off, comp_off, cmp_hold, cmp_start_a, cmp_start_b, done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic poked = 1'b0;

  always #2 clk = ~clk;

  sweep_seq_top #(.N_IN(NI), .N_PROD(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pla_x(pla_x),
    .true_off(true_off), .comp_off(comp_off), .prod_off(prod_off),
    .phase(phase), .cmp_hold(cmp_hold), .cmp_start_a(cmp_start_a),
    .cmp_start_b(cmp_start_b), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired got %0d cycles expected below 100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cmp(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got %h expected %h", req, what, got, exp);
    end
  endtask

  // k < 0: idle, 0..LEN-1: pattern index, >= LEN: done
  task automatic chk(int k);
    int ph, i, j, t;
    logic [NI-1:0] ex;
    logic [NP-1:0] eoff;
    logic c1, c2, hold, sa, sb;
    string req;
    i = 0; j = 0;
    if (k < 0) ph = 0;
    else if (k == 0) ph = 1;
    else if (k <= NP) begin ph = 2; j = k - 1; end
    else if (k <= 2 * NP) begin ph = 3; j = k - 1 - NP; end
    else begin
      t = k - 1 - 2 * NP;
      if (t < NI * NP) ph = 4;
      else if (t < 2 * NI * NP) begin ph = 5; t = t - NI * NP; end
      else ph = 6;
      i = t / NP; j = t % NP;
    end
    eoff = '1; ex = '0; c1 = 1'b0; c2 = 1'b0; sa = 1'b0; sb = 1'b0; hold = 1'b1;
    case (ph)
      0: req = "R1";
      1: begin req = "R2"; sa = 1'b1; end
      2: begin req = "R3"; c1 = 1; c2 = 1; eoff[j] = 1'b0; end
      3: begin req = "R3"; c1 = 1; c2 = 1; eoff[j] = 1'b0; ex = '1; sb = (j == 0); end
      4: begin req = "R4"; c2 = 1; eoff[j] = 1'b0; ex[i] = 1'b1; hold = (j != NP - 1); end
      5: begin req = "R5"; c1 = 1; eoff[j] = 1'b0; ex = '1; ex[i] = 1'b0; hold = (j != NP - 1); end
      default: req = "R7";
    endcase
    if (poked) req = {req, "/R9"};
    cmp(req, "phase", 32'(phase), 32'(ph));
    cmp(req, "true_off", 32'(true_off), 32'(c1));
    cmp(req, "comp_off", 32'(comp_off), 32'(c2));
    cmp({req, "/R8"}, "prod_off", 32'(prod_off), 32'(eoff));
    cmp(req, "pla_x", 32'(pla_x), 32'(ex));
    cmp("R6", "cmp_hold", 32'(cmp_hold), 32'(hold));
    cmp(req, "cmp_start_a", 32'(cmp_start_a), 32'(sa));
    cmp(req, "cmp_start_b", 32'(cmp_start_b), 32'(sb));
    cmp(req, "done", 32'(done), 32'(ph == 6));
  endtask

  initial begin
    int rest;
    int unused;
    unused = $urandom(32'd4242);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(-1);  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    rest = -1;
    for (int run = 0; run < 6; run++) begin
      int gap;
      gap = (run == 0) ? 2 : ((run == 3) ? 0 : int'($urandom % 4));
      poked = 1'b0;
      for (int g = 0; g < gap; g++) begin
        chk(rest);  // R7 done holds / R1 idle holds
        @(negedge clk);
      end
      chk(rest);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < LEN; k++) begin
        chk(k);
        start = (run > 0) && (($urandom % 8) == 0);  // R9 stray starts
        @(negedge clk);
        poked = start;
      end
      start = 1'b0;
      chk(LEN);  // R7 length and normal mode
      poked = 1'b0;
      @(negedge clk);
      rest = LEN;
    end
    chk(rest);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule